// File: doc/BRIEF.md
# USB Host Port Interrupt Controller

This block watches the events of one USB host port and turns them into a single level-sensitive interrupt line. The events are: the supply-valid comparator changing state, the OTG identification pin changing state, a device being attached or detached (seen on the port line state), a tick from the frame-start/end-of-packet timer, a remote-wakeup indication, and the completion of a bus transaction with a qualifying handshake. Each event sets a sticky flag in a status register. A 16-bit enable register selects which flags may drive the interrupt output.

Software uses a small register bus with two addresses. Address 0 is the enable register, which is read/write. Address 1 is the status register, where writing 1 to a bit clears it. Read data is combinational on the selected address. The bus has no wait states and no handshake. Every input is a plain control pin, and nothing in the block streams data. The parameter `HOST_INDEX` selects the controller's position. Only the first controller has the supply and ID event bits. The comparator, ID and line-state inputs are asynchronous and pass through two synchronizing flops, then through one more flop that serves as the edge reference. Those flops have no reset, so reset must be held for at least three clock cycles to let them settle.

Top module: `usb_host_irq`

## Requirements
- R1: After reset the enable register reads 0x0000, the status register reads 0x0000 and `irq` is low.
- R2: Only enable bits 15 (supply), 14 (ID), 9 (frame timer), 6 (wakeup), 4 (connect change) and 0 (transfer done) can be written, with 1 meaning enabled. All other bits of either register always read 0; in the first controller, writing 0xFFFF to the enable register reads back 0xC251.
- R3: With `HOST_INDEX` other than 1, bits 15 and 14 of both registers are reserved: writes to them are ignored, they read 0 and no supply or ID event is recorded.
- R4: Both a rising and a falling edge of `supply_ok_async` set status bit 15, at most four clock cycles after the change.
- R5: Both a rising and a falling edge of `otg_id_async` set status bit 14.
- R6: `line_state_async` is coded 2'b00 SE0, 2'b01 J, 2'b10 K, 2'b11 SE1. Status bit 4 is set by an SE0-to-J or J-to-SE0 change and by no other change.
- R7: A cycle with `xfer_done` high sets status bit 0 when `xfer_code` is 0 (host ACK), 1 (device ACK), 2 (device NAK), 3 (device STALL) or 4 (timeout); codes 5 to 7 do not set it.
- R8: A high cycle on `sof_tick` sets status bit 9, and a high cycle on `wake_evt` sets status bit 6, on the next clock edge.
- R9: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R10: `irq` is high exactly while some status bit and its matching enable bit are both 1.
- R11: An event is recorded in the status register even while its enable bit is 0.
- R12: When an event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high together with `bus_sel` |
| bus_addr | input | 1 | 0 = enable register, 1 = status register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| supply_ok_async | input | 1 | Supply-valid comparator output (asynchronous) |
| otg_id_async | input | 1 | OTG identification pin (asynchronous) |
| line_state_async | input | 2 | Port line state (asynchronous) |
| sof_tick | input | 1 | Frame timer event pulse |
| wake_evt | input | 1 | Remote-wakeup event pulse |
| xfer_done | input | 1 | Transaction completion strobe |
| xfer_code | input | 3 | Completion outcome, valid with `xfer_done` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two instances that share every input: one with `HOST_INDEX` = 1 and one with `HOST_INDEX` = 2. Because each stimulus reaches both, the same supply and ID toggles that must set bits 15 and 14 in the first controller must leave them clear in the second. An all-ones write to the enable register shows both reserved masks side by side. The remaining event detectors, the sticky status behaviour, and the case where an event and a clear land in the same cycle are checked on the first instance.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned BIT_SUPPLY = 15;
  localparam int unsigned BIT_ID     = 14;
  localparam int unsigned BIT_FRAME  = 9;
  localparam int unsigned BIT_WAKE   = 6;
  localparam int unsigned BIT_CONN   = 4;
  localparam int unsigned BIT_DONE   = 0;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_state_e;

  typedef enum logic [2:0] {
    XC_HOST_ACK  = 3'd0,
    XC_DEV_ACK   = 3'd1,
    XC_DEV_NAK   = 3'd2,
    XC_DEV_STALL = 3'd3,
    XC_TIMEOUT   = 3'd4
  } xfer_code_e;

  function automatic logic [REG_W-1:0] impl_mask(input int host_index);
    logic [REG_W-1:0] m;
    m = '0;
    m[BIT_FRAME] = 1'b1;
    m[BIT_WAKE]  = 1'b1;
    m[BIT_CONN]  = 1'b1;
    m[BIT_DONE]  = 1'b1;
    if (host_index == 1) begin
      m[BIT_SUPPLY] = 1'b1;
      m[BIT_ID]     = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/usb_irq_sync2.sv
module usb_irq_sync2 #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  // Unreset on purpose: the chain settles while reset is held.
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    stage1_q <= d_async;
    stage2_q <= stage1_q;
  end

  assign q_sync = stage2_q;
endmodule

// File: rtl/usb_irq_events.sv
module usb_irq_events
  import usb_irq_pkg::*;
#(
  parameter bit OTG_EN = 1'b1
) (
  input  logic             clk,
  input  logic             supply_ok_async,
  input  logic             otg_id_async,
  input  logic [1:0]       line_state_async,
  input  logic             sof_tick,
  input  logic             wake_evt,
  input  logic             xfer_done,
  input  logic [2:0]       xfer_code,
  output logic [REG_W-1:0] evt_vec
);
  logic       supply_evt;
  logic       id_evt;
  logic [1:0] line_s;
  logic [1:0] line_prev_q;
  logic       conn_evt;
  logic       done_evt;

  generate
    if (OTG_EN) begin : g_otg
      logic [1:0] otg_s;
      logic [1:0] otg_prev_q;
      usb_irq_sync2 #(.WIDTH(2)) u_sync_otg (
        .clk     (clk),
        .d_async ({supply_ok_async, otg_id_async}),
        .q_sync  (otg_s)
      );
      always_ff @(posedge clk) otg_prev_q <= otg_s;
      assign supply_evt = otg_s[1] ^ otg_prev_q[1];
      assign id_evt     = otg_s[0] ^ otg_prev_q[0];
    end else begin : g_no_otg
      assign supply_evt = 1'b0;
      assign id_evt     = 1'b0;
    end
  endgenerate

  usb_irq_sync2 #(.WIDTH(2)) u_sync_line (
    .clk     (clk),
    .d_async (line_state_async),
    .q_sync  (line_s)
  );

  always_ff @(posedge clk) line_prev_q <= line_s;

  always_comb begin
    conn_evt = ((line_prev_q == LS_SE0) && (line_s == LS_J)) ||
               ((line_prev_q == LS_J)   && (line_s == LS_SE0));
  end

  always_comb begin
    done_evt = 1'b0;
    if (xfer_done) begin
      case (xfer_code)
        XC_HOST_ACK, XC_DEV_ACK, XC_DEV_NAK, XC_DEV_STALL, XC_TIMEOUT: done_evt = 1'b1;
        default: done_evt = 1'b0;
      endcase
    end
  end

  always_comb begin
    evt_vec             = '0;
    evt_vec[BIT_SUPPLY] = supply_evt;
    evt_vec[BIT_ID]     = id_evt;
    evt_vec[BIT_FRAME]  = sof_tick;
    evt_vec[BIT_WAKE]   = wake_evt;
    evt_vec[BIT_CONN]   = conn_evt;
    evt_vec[BIT_DONE]   = done_evt;
  end
endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs
  import usb_irq_pkg::*;
#(
  parameter logic [15:0] IMPL_MASK = 16'h0251
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  input  logic [REG_W-1:0] evt_vec,
  output logic [REG_W-1:0] enable_q,
  output logic [REG_W-1:0] status_q,
  output logic [REG_W-1:0] bus_rdata
);
  logic             wr_enable;
  logic             wr_status;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] status_d;

  assign wr_enable = bus_sel && bus_wr && !bus_addr;
  assign wr_status = bus_sel && bus_wr && bus_addr;
  assign clr_vec   = wr_status ? bus_wdata : '0;
  // Setting after clearing lets a same-cycle event win.
  assign status_d  = ((status_q & ~clr_vec) | evt_vec) & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      status_q <= '0;
    end else begin
      if (wr_enable) enable_q <= bus_wdata & IMPL_MASK;
      status_q <= status_d;
    end
  end

  assign bus_rdata = bus_addr ? status_q : enable_q;
endmodule

// File: rtl/usb_host_irq.sv
module usb_host_irq
  import usb_irq_pkg::*;
#(
  parameter int HOST_INDEX = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        supply_ok_async,
  input  logic        otg_id_async,
  input  logic [1:0]  line_state_async,
  input  logic        sof_tick,
  input  logic        wake_evt,
  input  logic        xfer_done,
  input  logic [2:0]  xfer_code,
  output logic        irq
);
  localparam logic [REG_W-1:0] IMPL_MASK = impl_mask(HOST_INDEX);
  localparam bit               OTG_EN    = (HOST_INDEX == 1);

  logic [REG_W-1:0] evt_vec;
  logic [REG_W-1:0] enable_q;
  logic [REG_W-1:0] status_q;

  usb_irq_events #(.OTG_EN(OTG_EN)) u_events (
    .clk              (clk),
    .supply_ok_async  (supply_ok_async),
    .otg_id_async     (otg_id_async),
    .line_state_async (line_state_async),
    .sof_tick         (sof_tick),
    .wake_evt         (wake_evt),
    .xfer_done        (xfer_done),
    .xfer_code        (xfer_code),
    .evt_vec          (evt_vec)
  );

  usb_irq_regs #(.IMPL_MASK(IMPL_MASK)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_vec   (evt_vec),
    .enable_q  (enable_q),
    .status_q  (status_q),
    .bus_rdata (bus_rdata)
  );

  assign irq = |(status_q & enable_q);
endmodule

// File: rtl/usb_host_irq_chk.sv
module usb_host_irq_chk #(
  parameter int          HOST_INDEX = 1,
  parameter logic [15:0] IMPL_MASK  = 16'hC251
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic        bus_addr,
  input logic [15:0] bus_rdata,
  input logic [15:0] evt_vec,
  input logic [15:0] enable_q,
  input logic [15:0] status_q,
  input logic        irq
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rdata & ~IMPL_MASK) == 16'h0));

  assert_enable_only_by_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && !bus_addr) |=> $stable(enable_q));

  assert_otg_absent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (HOST_INDEX != 1) |-> (enable_q[15:14] == 2'b00 && status_q[15:14] == 2'b00));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr) |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_set_only_by_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_vec)) == 16'h0));

  assert_event_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != 16'h0) |=> ((status_q & $past(evt_vec)) == $past(evt_vec)));

  assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == 16'h0) |-> !irq);
endmodule

bind usb_host_irq usb_host_irq_chk #(.HOST_INDEX(HOST_INDEX), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .evt_vec   (evt_vec),
  .enable_q  (enable_q),
  .status_q  (status_q),
  .irq       (irq)
);

// File: tb/test_usb_host_irq.sv
module test_usb_host_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] rdata_a;
  logic [15:0] rdata_b;
  logic        supply_ok = 1'b0;
  logic        otg_id = 1'b0;
  logic [1:0]  line_st = 2'b00;
  logic        sof_tick = 1'b0;
  logic        wake_evt = 1'b0;
  logic        xfer_done = 1'b0;
  logic [2:0]  xfer_code = 3'd0;
  logic        irq_a;
  logic        irq_b;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  usb_host_irq #(.HOST_INDEX(1)) i_usb_host_irq (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .supply_ok_async(supply_ok),
    .otg_id_async(otg_id), .line_state_async(line_st), .sof_tick(sof_tick),
    .wake_evt(wake_evt), .xfer_done(xfer_done), .xfer_code(xfer_code), .irq(irq_a)
  );

  usb_host_irq #(.HOST_INDEX(2)) i_usb_host_irq_b (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .supply_ok_async(supply_ok),
    .otg_id_async(otg_id), .line_state_async(line_st), .sof_tick(sof_tick),
    .wake_evt(wake_evt), .xfer_done(xfer_done), .xfer_code(xfer_code), .irq(irq_b)
  );

  // Vector: [7] kind (0 line, 1 transfer), [6:4] first value / code, [3:1] second line value, [0] expected bit
  localparam logic [7:0] VEC [0:14] = '{
    8'h03, 8'h11, 8'h14, 8'h22, 8'h04, 8'h20, 8'h32,
    8'h81, 8'h91, 8'hA1, 8'hB1, 8'hC1, 8'hD0, 8'hE0, 8'hF0
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic addr, input logic [15:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 16'h0;
  endtask

  task automatic bus_read(input logic addr, output logic [15:0] a, output logic [15:0] b);
    @(negedge clk);
    bus_addr = addr;
    #1;
    a = rdata_a;
    b = rdata_b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] ra, rb;
    wait_clk(6);
    rst_n = 1'b1;
    wait_clk(1);

    // R1 reset state
    bus_read(1'b0, ra, rb);
    check("R1 enable A", ra, 16'h0000);
    check("R1 enable B", rb, 16'h0000);
    bus_read(1'b1, ra, rb);
    check("R1 status A", ra, 16'h0000);
    check("R1 irq", {15'h0, irq_a}, 16'h0);

    // R2 / R3 writable masks
    bus_write(1'b0, 16'hFFFF);
    bus_read(1'b0, ra, rb);
    check("R2 enable mask A", ra, 16'hC251);
    check("R3 enable mask B", rb, 16'h0251);
    bus_write(1'b0, 16'h0000);

    // R6 / R7 vector table
    for (int v = 0; v < 15; v++) begin
      if (!VEC[v][7]) begin
        @(negedge clk) line_st = VEC[v][5:4];
        wait_clk(5);
        bus_write(1'b1, 16'hFFFF);
        @(negedge clk) line_st = VEC[v][2:1];
        wait_clk(5);
        bus_read(1'b1, ra, rb);
        check($sformatf("R6 line %0d->%0d", VEC[v][5:4], VEC[v][2:1]),
              {15'h0, ra[4]}, {15'h0, VEC[v][0]});
      end else begin
        bus_write(1'b1, 16'hFFFF);
        @(negedge clk);
        xfer_done = 1'b1; xfer_code = VEC[v][6:4];
        @(negedge clk);
        xfer_done = 1'b0;
        bus_read(1'b1, ra, rb);
        check($sformatf("R7 code %0d", VEC[v][6:4]), {15'h0, ra[0]}, {15'h0, VEC[v][0]});
      end
    end
    @(negedge clk) line_st = 2'b00;
    wait_clk(5);
    bus_write(1'b1, 16'hFFFF);

    // R4 supply both edges, R3 second instance ignores
    @(negedge clk) supply_ok = 1'b1;
    wait_clk(4);
    bus_read(1'b1, ra, rb);
    check("R4 supply rise", ra, 16'h8000);
    check("R3 supply B", rb, 16'h0000);
    bus_write(1'b1, 16'h8000);
    @(negedge clk) supply_ok = 1'b0;
    wait_clk(4);
    bus_read(1'b1, ra, rb);
    check("R4 supply fall", ra, 16'h8000);
    bus_write(1'b1, 16'hFFFF);

    // R5 ID both edges
    @(negedge clk) otg_id = 1'b1;
    wait_clk(4);
    bus_read(1'b1, ra, rb);
    check("R5 id rise", ra, 16'h4000);
    check("R3 id B", rb, 16'h0000);
    bus_write(1'b1, 16'hFFFF);
    @(negedge clk) otg_id = 1'b0;
    wait_clk(4);
    bus_read(1'b1, ra, rb);
    check("R5 id fall", ra, 16'h4000);
    bus_write(1'b1, 16'hFFFF);

    // R8 frame tick and wakeup; R11 recorded with enables at 0
    @(negedge clk) sof_tick = 1'b1;
    @(negedge clk) sof_tick = 1'b0;
    bus_read(1'b1, ra, rb);
    check("R8 frame tick", ra, 16'h0200);
    check("R11 irq off while disabled", {15'h0, irq_a}, 16'h0);
    @(negedge clk) wake_evt = 1'b1;
    @(negedge clk) wake_evt = 1'b0;
    bus_read(1'b1, ra, rb);
    check("R8 wakeup", ra, 16'h0240);

    // R10 interrupt gating
    bus_write(1'b0, 16'h0010);
    check("R10 irq other bit only", {15'h0, irq_a}, 16'h0);
    bus_write(1'b0, 16'h0200);
    check("R10 irq enabled", {15'h0, irq_a}, 16'h1);

    // R9 writing 0 keeps, writing 1 clears
    bus_write(1'b1, 16'h0000);
    bus_read(1'b1, ra, rb);
    check("R9 write zero keeps", ra, 16'h0240);
    bus_write(1'b1, 16'h0200);
    bus_read(1'b1, ra, rb);
    check("R9 clear one bit", ra, 16'h0040);
    check("R10 irq after clear", {15'h0, irq_a}, 16'h0);

    // R12 event and clear in the same cycle
    @(negedge clk) sof_tick = 1'b1;
    @(negedge clk) sof_tick = 1'b0;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 16'h0200; sof_tick = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 16'h0; sof_tick = 1'b0;
    bus_read(1'b1, ra, rb);
    check("R12 event beats clear", ra, 16'h0240);
    check("R12 irq stays", {15'h0, irq_a}, 16'h1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule